// File: doc/BRIEF.md
# Cascadable Quadrature Phase Counter

The block counts motion reported by incremental encoders or pulse/direction sources. Two phase counters, each `CW` bits wide, run side by side. Channel 1 always reads the A/B input pair. Channel 2 reads either A/B or C/D. Each channel runs in one of three decoding modes: pulse-direction, quadrature x2 or quadrature x4. Setting the cascade bit joins the two channels into one counter of width `2*CW`. Channel 1 then holds the low half and feeds its carry or borrow to channel 2 in the same clock. The cascaded count uses channel 2's mode, enable and pair select.

Every phase input passes through a synchronizer of `SYNC_STAGES` flops. Each channel then has a decoder, a small state machine whose state is the last sampled pair {A,B}. The states are PH_00, PH_10, PH_11 and PH_01.
- Forward transitions: PH_00→PH_10, PH_10→PH_11, PH_11→PH_01 and PH_01→PH_00.
- Reverse transitions: the same four steps taken backwards.
- Any jump that changes both bits is invalid.
- Staying in the same state is idle.

Each count has its own ceiling. Counting up from the ceiling clears the count to zero. Counting down from zero loads the ceiling. A flat register port handles control, preloading, ceilings and read-back.

Top module: `quad_cascade_counter`

## Requirements
- R1: After reset, both counts read 0, the control register reads 0 (both channels paused, pulse-direction mode, pair A/B, no cascade), and every ceiling reads all ones.
- R2: A phase input change reaches the count through a two-flop synchronizer and one decoder compare. The count shows the step after the third rising clock edge that follows the change.
- R3: Mode code 0 (pulse-direction) counts on each rising edge of the first input of the pair. It counts up when the second input is 1 and down when it is 0. Falling edges of the first input and any change of the second input do not count.
- R4: Mode code 1 (quadrature x2) counts only on single-input changes of the second input. Forward transitions of {first,second} in the order 00→10→11→01→00 count up, and the reverse order counts down. Changes of the first input alone do not count.
- R5: Mode code 2 (quadrature x4) counts on every single-input change of either input, with the same forward and reverse order as R4. Mode code 3 never counts.
- R6: In the quadrature modes, a sample in which both inputs of the pair change at once leaves the count unchanged.
- R7: An up step at a count equal to or above the ceiling gives 0. A down step at 0 gives the ceiling. A ceiling of 0 holds the count at 0 in both directions.
- R8: Clearing a channel's enable bit freezes its count with the value kept. Setting the bit again resumes counting from that value.
- R9: A software write to a count takes effect only when the written value is less than or equal to that count's current ceiling. Otherwise the count keeps its value.
- R10: Control bit 6 set makes channel 2 (and the cascaded count) decode C as the first input and D as the second. Channel 1 always decodes A and B.
- R11: Control bit 7 set joins the channels into the wide count {channel 2, channel 1}. Channel 1 carries into or borrows from channel 2 in the same cycle. The wide count uses channel 2's mode (control bits 5:4), enable (bit 1), pair select and the wide ceiling. Writes to the single-channel count addresses are ignored in this mode, and writes to the wide count address are ignored outside it.
- R12: Register addresses:
  - 0: control (bit 0 channel 1 enable, bit 1 channel 2 enable, bits 3:2 channel 1 mode, bits 5:4 channel 2 mode, bit 6 pair select, bit 7 cascade)
  - 1: channel 1 count
  - 2: channel 2 count
  - 3: wide count
  - 4: channel 1 ceiling
  - 5: channel 2 ceiling
  - 6: wide ceiling

  Reads are combinational from `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_a | input | 1 | Phase input A (asynchronous) |
| ph_b | input | 1 | Phase input B (asynchronous) |
| ph_c | input | 1 | Phase input C (asynchronous) |
| ph_d | input | 1 | Phase input D (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 2*CW | Register write data |
| rdata | output | 2*CW | Register read data |
| cnt_lo | output | CW | Channel 1 count (low half when cascaded) |
| cnt_hi | output | CW | Channel 2 count (high half when cascaded) |

## Verification
The bench builds the block with its default parameters: 16-bit channels and a two-flop synchronizer, so the three-edge latency of R2 is the one checked. Ceiling writes and count preloads place the counts right beside their boundaries, so a handful of phase steps reach the wrap to zero, the load of the ceiling and the carry across the 16-bit halves. A behavioural model in the bench tracks both counts and is compared with the outputs on every clock.

// File: rtl/pqc_pkg.sv
package pqc_pkg;

    typedef enum logic [1:0] {
        MD_PULSE = 2'd0,
        MD_X2    = 2'd1,
        MD_X4    = 2'd2,
        MD_OFF   = 2'd3
    } mode_t;

    // decoder state: last sampled {first, second} input pair
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } ph_t;

    typedef struct packed {
        logic  cascade;
        logic  sel_cd;
        mode_t mode2;
        mode_t mode1;
        logic  en2;
        logic  en1;
    } ctrl_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] RA_CNT1   = 3'd1;
    localparam logic [ADDR_W-1:0] RA_CNT2   = 3'd2;
    localparam logic [ADDR_W-1:0] RA_CNTW   = 3'd3;
    localparam logic [ADDR_W-1:0] RA_CEIL1  = 3'd4;
    localparam logic [ADDR_W-1:0] RA_CEIL2  = 3'd5;
    localparam logic [ADDR_W-1:0] RA_CEILW  = 3'd6;

endpackage

// File: rtl/pqc_sync.sv
module pqc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pqc_decode.sv
module pqc_decode
    import pqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pa,
    input  logic  pb,
    input  mode_t mode,
    output logic  up,
    output logic  dn
);

    ph_t        state_q;
    ph_t        cur;
    logic [1:0] prev_bits;
    logic       fwd_a, fwd_b, rev_a, rev_b;
    logic       a_rise;

    assign cur       = ph_t'({pa, pb});
    assign prev_bits = state_q;

    // state register: follows the sampled pair every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_00;
        end else begin
            state_q <= cur;
        end
    end

    // transition classification
    always_comb begin
        fwd_a = 1'b0;
        fwd_b = 1'b0;
        rev_a = 1'b0;
        rev_b = 1'b0;
        unique case (state_q)
            PH_00: begin
                fwd_a = (cur == PH_10);
                rev_b = (cur == PH_01);
            end
            PH_10: begin
                fwd_b = (cur == PH_11);
                rev_a = (cur == PH_00);
            end
            PH_11: begin
                fwd_a = (cur == PH_01);
                rev_b = (cur == PH_10);
            end
            PH_01: begin
                fwd_b = (cur == PH_00);
                rev_a = (cur == PH_11);
            end
        endcase
    end

    assign a_rise = !prev_bits[1] && pa;

    // output process: mode picks which transitions count
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (mode)
            MD_PULSE: begin
                up = a_rise && pb;
                dn = a_rise && !pb;
            end
            MD_X2: begin
                up = fwd_b;
                dn = rev_b;
            end
            MD_X4: begin
                up = fwd_a || fwd_b;
                dn = rev_a || rev_b;
            end
            MD_OFF: begin
                up = 1'b0;
                dn = 1'b0;
            end
        endcase
    end

    // R6: a two-bit jump never yields a quadrature step
    assert_no_jump_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MD_PULSE) && ((prev_bits ^ {pa, pb}) == 2'b11)) |-> (!up && !dn));

    // R3: pulse-direction mode never steps while the first input is low
    assert_pulse_needs_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_PULSE) && !pa) |-> (!up && !dn));

    // R4: x2 mode never steps while the second input holds its level
    assert_x2_b_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_X2) && (prev_bits[0] == pb)) |-> (!up && !dn));

    assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

endmodule

// File: rtl/pqc_chan.sv
module pqc_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up,
    input  logic          dn,
    input  logic [CW-1:0] ceil,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          carry,
    output logic          borrow
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    assign carry  = up && (cnt_q >= ceil);
    assign borrow = dn && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (up) begin
            cnt_q <= carry ? '0 : cnt_q + ONE;
        end else if (dn) begin
            cnt_q <= borrow ? ceil : cnt_q - ONE;
        end
    end

    assign cnt = cnt_q;

    // R7: up step at or beyond the ceiling returns to zero
    assert_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !load && (cnt_q >= ceil)) |=> (cnt_q == '0));

    // R7: down step at zero lands on the ceiling
    assert_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !up && !load && (cnt_q == '0)) |=> (cnt_q == $past(ceil)));

    // R8: with no step and no load the count holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter
    import pqc_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ph_a,
    input  logic               ph_b,
    input  logic               ph_c,
    input  logic               ph_d,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [2*CW-1:0]    wdata,
    output logic [2*CW-1:0]    rdata,
    output logic [CW-1:0]      cnt_lo,
    output logic [CW-1:0]      cnt_hi
);

    localparam int DW = 2 * CW;
    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [CW-1:0] ONE = CW'(1);

    // ---------------- registers ----------------
    ctrl_t         ctrl_q;
    logic [CW-1:0] ceil1_q, ceil2_q;
    logic [DW-1:0] ceilw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            ceil1_q <= '1;
            ceil2_q <= '1;
            ceilw_q <= '1;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL:  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
                RA_CEIL1: ceil1_q <= wdata[CW-1:0];
                RA_CEIL2: ceil2_q <= wdata[CW-1:0];
                RA_CEILW: ceilw_q <= wdata;
                default: ;
            endcase
        end
    end

    // ---------------- input path ----------------
    logic [3:0] ph_s;

    pqc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ph_d, ph_c, ph_b, ph_a}),
        .q     (ph_s)
    );

    logic up1_raw, dn1_raw, up2_raw, dn2_raw;
    logic pa2, pb2;

    assign pa2 = ctrl_q.sel_cd ? ph_s[2] : ph_s[0];
    assign pb2 = ctrl_q.sel_cd ? ph_s[3] : ph_s[1];

    pqc_decode u_dec1 (
        .clk   (clk),
        .rst_n (rst_n),
        .pa    (ph_s[0]),
        .pb    (ph_s[1]),
        .mode  (ctrl_q.mode1),
        .up    (up1_raw),
        .dn    (dn1_raw)
    );

    pqc_decode u_dec2 (
        .clk   (clk),
        .rst_n (rst_n),
        .pa    (pa2),
        .pb    (pb2),
        .mode  (ctrl_q.mode2),
        .up    (up2_raw),
        .dn    (dn2_raw)
    );

    // ---------------- step and load steering ----------------
    logic          casc;
    logic          st1_up, st1_dn, st2_up, st2_dn;
    logic [DW-1:0] wide;
    logic          wrap_up, wrap_dn;
    logic          wr_c1_ok, wr_c2_ok, wr_cw_ok;
    logic          load1, load2;
    logic [CW-1:0] lval1, lval2;
    logic [CW-1:0] ceil_ch1, ceil_ch2;
    logic          up_ch2, dn_ch2;
    logic          carry1, borrow1, carry2, borrow2;

    assign casc   = ctrl_q.cascade;
    assign st1_up = casc ? (ctrl_q.en2 && up2_raw) : (ctrl_q.en1 && up1_raw);
    assign st1_dn = casc ? (ctrl_q.en2 && dn2_raw) : (ctrl_q.en1 && dn1_raw);
    assign st2_up = ctrl_q.en2 && up2_raw;
    assign st2_dn = ctrl_q.en2 && dn2_raw;

    assign wide    = {cnt_hi, cnt_lo};
    assign wrap_up = casc && st1_up && (wide >= ceilw_q);
    assign wrap_dn = casc && st1_dn && (wide == '0);

    assign wr_c1_ok = wr_en && (addr == RA_CNT1) && !casc && (wdata <= {{CW{1'b0}}, ceil1_q});
    assign wr_c2_ok = wr_en && (addr == RA_CNT2) && !casc && (wdata <= {{CW{1'b0}}, ceil2_q});
    assign wr_cw_ok = wr_en && (addr == RA_CNTW) &&  casc && (wdata <= ceilw_q);

    always_comb begin
        load1 = wr_c1_ok || wr_cw_ok || wrap_up || wrap_dn;
        if (wr_c1_ok || wr_cw_ok) begin
            lval1 = wdata[CW-1:0];
        end else if (wrap_up) begin
            lval1 = '0;
        end else begin
            lval1 = ceilw_q[CW-1:0];
        end
    end

    always_comb begin
        load2 = wr_c2_ok || wr_cw_ok || wrap_up || wrap_dn;
        if (wr_c2_ok) begin
            lval2 = wdata[CW-1:0];
        end else if (wr_cw_ok) begin
            lval2 = wdata[DW-1:CW];
        end else if (wrap_up) begin
            lval2 = '0;
        end else begin
            lval2 = ceilw_q[DW-1:CW];
        end
    end

    assign ceil_ch1 = casc ? '1 : ceil1_q;
    assign ceil_ch2 = casc ? '1 : ceil2_q;
    assign up_ch2   = casc ? carry1  : st2_up;
    assign dn_ch2   = casc ? borrow1 : st2_dn;

    pqc_chan #(.CW(CW)) u_ch1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .up       (st1_up),
        .dn       (st1_dn),
        .ceil     (ceil_ch1),
        .load     (load1),
        .load_val (lval1),
        .cnt      (cnt_lo),
        .carry    (carry1),
        .borrow   (borrow1)
    );

    pqc_chan #(.CW(CW)) u_ch2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .up       (up_ch2),
        .dn       (dn_ch2),
        .ceil     (ceil_ch2),
        .load     (load2),
        .load_val (lval2),
        .cnt      (cnt_hi),
        .carry    (carry2),
        .borrow   (borrow2)
    );

    // ---------------- read mux ----------------
    always_comb begin
        case (addr)
            RA_CTRL:  rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            RA_CNT1:  rdata = {{CW{1'b0}}, cnt_lo};
            RA_CNT2:  rdata = {{CW{1'b0}}, cnt_hi};
            RA_CNTW:  rdata = wide;
            RA_CEIL1: rdata = {{CW{1'b0}}, ceil1_q};
            RA_CEIL2: rdata = {{CW{1'b0}}, ceil2_q};
            RA_CEILW: rdata = ceilw_q;
            default:  rdata = '0;
        endcase
    end

    // R11: low half rolls over into the high half in the same cycle
    assert_cascade_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && st1_up && (cnt_lo == '1) && !wrap_up && !wr_en)
            |=> ((cnt_lo == '0) && (cnt_hi == $past(cnt_hi) + ONE)));

    // R8: paused channel 1 holds its count when nothing is written
    assert_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc && !ctrl_q.en1 && !wr_en) |=> $stable(cnt_lo));

    // R9: an over-ceiling write to a paused channel leaves it untouched
    assert_reject_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == RA_CNT1) && !casc && !ctrl_q.en1
            && (wdata > {{CW{1'b0}}, ceil1_q})) |=> $stable(cnt_lo));

    // R11: in cascade the channel-2 half never moves without a low-half event
    assert_hi_follows_lo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && !st1_up && !st1_dn && !wr_en) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

endmodule

// File: tb/sim_quad_cascade_counter.sv
module sim_quad_cascade_counter;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int DW = 2 * CW;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ph_a, ph_b, ph_c, ph_d;
    logic          wr_en;
    logic [2:0]    addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [CW-1:0] cnt_lo, cnt_hi;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_cascade_counter #(.CW(CW), .SYNC_STAGES(2)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_a   (ph_a),
        .ph_b   (ph_b),
        .ph_c   (ph_c),
        .ph_d   (ph_d),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi)
    );

    // ---------------- behavioural reference model ----------------
    longint     m1, m2, c1, c2, cw;
    logic [7:0] mctrl;
    logic [3:0] s1, s2;
    logic [1:0] prev1, prev2;

    function automatic int pos(logic [1:0] p);
        case (p)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int dec(logic [1:0] md, logic [1:0] p, logic [1:0] c);
        int d;
        int r;
        d = (pos(c) - pos(p) + 4) % 4;
        r = 0;
        if (md == 2'd0) begin
            if (!p[1] && c[1]) r = c[0] ? 1 : -1;
        end else if (md == 2'd2 || (md == 2'd1 && p[0] != c[0])) begin
            if (d == 1) r = 1;
            else if (d == 3) r = -1;
        end
        return r;
    endfunction

    function automatic longint stepv(longint v, int d, longint ceil);
        if (d == 1)  return (v >= ceil) ? 0 : v + 1;
        if (d == -1) return (v == 0) ? ceil : v - 1;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; c1 = 64'hFFFF; c2 = 64'hFFFF; cw = 64'hFFFF_FFFF;
            mctrl = '0; s1 = '0; s2 = '0; prev1 = '0; prev2 = '0;
        end else begin
            logic [1:0] pair1, pair2;
            int d1, d2;
            longint v, wv;
            wv = longint'(wdata);
            pair1 = {s2[0], s2[1]};
            pair2 = mctrl[6] ? {s2[2], s2[3]} : {s2[0], s2[1]};
            d1 = mctrl[0] ? dec(mctrl[3:2], prev1, pair1) : 0;
            d2 = mctrl[1] ? dec(mctrl[5:4], prev2, pair2) : 0;
            if (mctrl[7]) begin
                v = m2 * 65536 + m1;
                if (wr_en && addr == 3'd3 && wv <= cw) v = wv;
                else v = stepv(v, d2, cw);
                m1 = v % 65536;
                m2 = v / 65536;
            end else begin
                if (wr_en && addr == 3'd1 && wv <= c1) m1 = wv;
                else m1 = stepv(m1, d1, c1);
                if (wr_en && addr == 3'd2 && wv <= c2) m2 = wv;
                else m2 = stepv(m2, d2, c2);
            end
            if (wr_en) begin
                case (addr)
                    3'd0: mctrl = wdata[7:0];
                    3'd4: c1 = longint'(wdata[15:0]);
                    3'd5: c2 = longint'(wdata[15:0]);
                    3'd6: cw = wv;
                    default: ;
                endcase
            end
            prev1 = pair1;
            prev2 = pair2;
            s2 = s1;
            s1 = {ph_d, ph_c, ph_b, ph_a};
        end
    end

    // every-clock comparison against the model (R2 timing, all modes)
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            total++;
            if (cnt_lo !== 16'(m1) || cnt_hi !== 16'(m2)) begin
                bad++;
                $display("FAIL R2 model compare act=%h_%h exp=%h_%h",
                         cnt_hi, cnt_lo, 16'(m2), 16'(m1));
            end
        end
    end

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog act=%0d expected below %0d", cyc, WATCHDOG);
            finish_up();
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic pins(logic a, logic b, logic c, logic d);
        ph_a = a; ph_b = b; ph_c = c; ph_d = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] ad, logic [DW-1:0] v);
        wr_en = 1'b1; addr = ad; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(string tag, logic [2:0] ad, longint exp);
        addr = ad;
        #1;
        chk(tag, longint'(rdata), exp);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0;
        ph_a = 0; ph_b = 0; ph_c = 0; ph_d = 0;
        wr_en = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cnt_lo", cnt_lo, 0);
        chk("R1 cnt_hi", cnt_hi, 0);
        rd("R1 ctrl", 3'd0, 0);
        rd("R1 ceil1", 3'd4, 64'hFFFF);
        rd("R1 ceilw", 3'd6, 64'hFFFF_FFFF);

        // R3 pulse-direction on channel 1
        wr(3'd0, 32'h01);
        pins(0, 1, 0, 0);
        chk("R3 second input change ignored", cnt_lo, 0);
        // R2 latency: visible after third edge
        ph_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 not yet after two edges", cnt_lo, 0);
        @(negedge clk);
        chk("R2 visible after third edge", cnt_lo, 1);
        repeat (2) @(negedge clk);
        pins(0, 1, 0, 0);
        chk("R3 falling edge ignored", cnt_lo, 1);
        pins(1, 1, 0, 0);
        pins(0, 1, 0, 0);
        pins(1, 1, 0, 0);
        chk("R3 up count", cnt_lo, 3);
        pins(1, 0, 0, 0);
        pins(0, 0, 0, 0);
        pins(1, 0, 0, 0);
        pins(0, 0, 0, 0);
        pins(1, 0, 0, 0);
        pins(0, 0, 0, 0);
        chk("R3 down count", cnt_lo, 1);

        // R4 quadrature x2
        wr(3'd0, 32'h05);
        pins(1, 0, 0, 0);
        chk("R4 first input alone ignored", cnt_lo, 1);
        pins(1, 1, 0, 0);
        pins(0, 1, 0, 0);
        pins(0, 0, 0, 0);
        chk("R4 forward cycle", cnt_lo, 3);
        pins(0, 1, 0, 0);
        pins(1, 1, 0, 0);
        pins(1, 0, 0, 0);
        pins(0, 0, 0, 0);
        chk("R4 reverse cycle", cnt_lo, 1);

        // R5 quadrature x4, R6 invalid jumps
        wr(3'd0, 32'h09);
        pins(1, 0, 0, 0);
        pins(1, 1, 0, 0);
        pins(0, 1, 0, 0);
        pins(0, 0, 0, 0);
        chk("R5 forward cycle", cnt_lo, 5);
        pins(0, 1, 0, 0);
        chk("R5 reverse step", cnt_lo, 4);
        pins(0, 0, 0, 0);
        pins(1, 1, 0, 0);
        chk("R6 double change 00->11", cnt_lo, 5);
        pins(0, 0, 0, 0);
        chk("R6 double change 11->00", cnt_lo, 5);

        // R7 ceiling wrap
        wr(3'd4, 32'd6);
        pins(1, 0, 0, 0);
        chk("R7 up to ceiling", cnt_lo, 6);
        pins(1, 1, 0, 0);
        chk("R7 wrap up to zero", cnt_lo, 0);
        pins(1, 0, 0, 0);
        chk("R7 wrap down to ceiling", cnt_lo, 6);
        wr(3'd4, 32'd0);
        pins(1, 1, 0, 0);
        chk("R7 zero ceiling up from above", cnt_lo, 0);
        pins(0, 1, 0, 0);
        chk("R7 zero ceiling up holds", cnt_lo, 0);
        pins(1, 1, 0, 0);
        chk("R7 zero ceiling down holds", cnt_lo, 0);

        // R9 software count writes
        wr(3'd4, 32'h100);
        wr(3'd1, 32'h200);
        chk("R9 over-ceiling write rejected", cnt_lo, 0);
        wr(3'd1, 32'h0FF);
        chk("R9 write below ceiling", cnt_lo, 16'h0FF);
        wr(3'd1, 32'h100);
        chk("R9 write equal to ceiling", cnt_lo, 16'h100);

        // R8 pause / resume
        wr(3'd4, 32'hFFFF);
        wr(3'd0, 32'h08);
        pins(1, 0, 0, 0);
        pins(0, 0, 0, 0);
        chk("R8 paused count held", cnt_lo, 16'h100);
        wr(3'd0, 32'h09);
        pins(1, 0, 0, 0);
        chk("R8 resumed count", cnt_lo, 16'h101);

        // R10 channel 2 on C/D
        wr(3'd0, 32'h68);
        wr(3'd0, 32'h6B);
        pins(1, 0, 1, 0);
        chk("R10 ch2 counts on C", cnt_hi, 1);
        chk("R10 ch1 ignores C", cnt_lo, 16'h101);
        pins(0, 0, 1, 0);
        chk("R10 ch1 counts on A", cnt_lo, 16'h100);
        chk("R10 ch2 ignores A", cnt_hi, 1);
        pins(0, 0, 1, 1);
        chk("R10 ch2 counts on D", cnt_hi, 2);

        // R11 cascade
        wr(3'd0, 32'hE0);
        wr(3'd3, 32'h0000_FFFE);
        chk("R11 wide preload low", cnt_lo, 16'hFFFE);
        chk("R11 wide preload high", cnt_hi, 0);
        wr(3'd0, 32'hE2);
        pins(0, 0, 0, 1);
        chk("R11 low half step", cnt_lo, 16'hFFFF);
        pins(0, 0, 0, 0);
        chk("R11 carry low", cnt_lo, 0);
        chk("R11 carry high", cnt_hi, 1);
        pins(0, 0, 0, 1);
        chk("R11 borrow low", cnt_lo, 16'hFFFF);
        chk("R11 borrow high", cnt_hi, 0);
        wr(3'd1, 32'd5);
        chk("R11 single write ignored", cnt_lo, 16'hFFFF);
        rd("R12 wide read", 3'd3, 64'h0000_FFFF);

        wr(3'd6, 32'h0001_0000);
        pins(0, 0, 0, 0);
        rd("R11 reach wide ceiling", 3'd3, 64'h0001_0000);
        pins(0, 0, 1, 0);
        rd("R7 wide wrap up", 3'd3, 0);
        pins(0, 0, 0, 0);
        rd("R7 wide wrap down", 3'd3, 64'h0001_0000);
        wr(3'd3, 32'h0002_0000);
        rd("R9 wide over-ceiling rejected", 3'd3, 64'h0001_0000);
        rd("R12 wide ceiling read", 3'd6, 64'h0001_0000);
        rd("R12 ctrl read", 3'd0, 64'hE2);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule